// File: doc/BRIEF.md
# Byte-Wide Indirect Register Write Port

This block lets a host with an 8-bit data bus and a 3-bit address bus write registers of up to 20 bits that live in a 10-bit internal address space. The host sets the target first. It writes the low eight address bits to external address 6 and the top two address bits to external address 7. It then writes any high-order data bytes it needs into two holding registers, at external address 2 for bits 19:16 and external address 1 for bits 15:8. Last, it writes the low data byte to external address 0.

The write to external address 0 is the commit. On the clock edge that samples it, the block builds the full word from the two holding registers and the incoming low byte. It presents that word, together with the assembled internal address, under a write strobe that lasts one cycle. The holding and address registers keep their contents after a commit. A run of writes to registers of the same width therefore needs only a new low byte, and a run to the same address needs no new address.

Top module: `ibw_port`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the holding registers, the address registers and the outputs, so `reg_wr_en`=0, `reg_addr`=0 and `reg_wdata`=0 after reset.
- R2: A host write (`host_we`=1) to external address 0 sets `reg_wr_en` high for the cycle that follows the edge that sampled it. Any cycle whose previous edge saw no such write has `reg_wr_en` low.
- R3: During the strobe, `reg_wdata` equals {DR2[3:0], DR1[7:0], low byte}, where the low byte is the data sampled with the address-0 write.
- R4: A write to external address 2 stores only data bits 3:0, which become word bits 19:16. Host data bits 7:4 of that write have no effect.
- R5: During the strobe, `reg_addr` equals {A7[1:0], A6[7:0]}. Address 6 holds the low address byte and address 7 holds the upper two bits. Bits 7:2 written to address 7 have no effect.
- R6: The holding and address registers keep their values across a commit. A later address-0 write reuses them.
- R7: Writes to external addresses 1, 2, 6 and 7 produce no strobe. Writes to addresses 3, 4 and 5 change no state.
- R8: A reset in the same cycle as an address-0 write suppresses the strobe.
- R9: With `host_we` low, no register changes, whatever the values on the address and data buses.
- R10: Outside a strobe, `reg_addr` and `reg_wdata` hold the values of the last commit, or zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write enable, one sample per clock |
| host_addr | input | 3 | External register select |
| host_wdata | input | 8 | Host write data byte |
| reg_wr_en | output | 1 | One-cycle internal write strobe |
| reg_addr | output | 10 | Internal target address |
| reg_wdata | output | 20 | Assembled internal write word |

## Verification
The assertions assume that the host presents at most one write per clock and that the address and data are valid whenever `host_we` is high. They also assume that reset is synchronous, so nothing is checked in a cycle that follows an edge at which reset was high. The stimulus changes every input on the falling edge only and draws addresses from all eight external codes, unused ones included. It issues one write per cycle, with idle gaps and back-to-back low-byte commits mixed in, and the bus carries random values while the write enable is low. Reset is raised once, in the same cycle as a commit, to exercise the suppression case.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
    localparam int HOST_AW = 3;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 20;
    localparam int IADDR_W = 10;
    localparam int TOP_W   = WORD_W - 2 * BYTE_W;
    localparam int AHI_W   = IADDR_W - BYTE_W;

    typedef enum logic [HOST_AW-1:0] {
        SEL_LOW   = 3'd0,
        SEL_MID   = 3'd1,
        SEL_TOP   = 3'd2,
        SEL_ALO   = 3'd6,
        SEL_AHI   = 3'd7
    } host_sel_e;

    typedef struct packed {
        logic low;
        logic mid;
        logic top;
        logic alo;
        logic ahi;
    } sel_t;

    typedef struct packed {
        logic [IADDR_W-1:0] addr;
        logic [WORD_W-1:0]  word;
    } commit_t;

    function automatic logic sel_hit(input logic we,
                                     input logic [HOST_AW-1:0] a,
                                     input host_sel_e s);
        return we && (a == s);
    endfunction

    function automatic logic [WORD_W-1:0] join_word(input logic [TOP_W-1:0] t,
                                                    input logic [BYTE_W-1:0] m,
                                                    input logic [BYTE_W-1:0] l);
        return {t, m, l};
    endfunction
endpackage

// File: rtl/ibw_decode.sv
module ibw_decode
    import ibw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    output sel_t               sel
);
    always_comb begin
        sel.low = sel_hit(host_we, host_addr, SEL_LOW);
        sel.mid = sel_hit(host_we, host_addr, SEL_MID);
        sel.top = sel_hit(host_we, host_addr, SEL_TOP);
        sel.alo = sel_hit(host_we, host_addr, SEL_ALO);
        sel.ahi = sel_hit(host_we, host_addr, SEL_AHI);
    end

    // R9: no select without write enable; at most one select per cycle
    p_sel_needs_we_r9: assert property (@(posedge clk) disable iff (rst)
        (sel != '0) |-> host_we);
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: rtl/ibw_addr_regs.sv
module ibw_addr_regs
    import ibw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  sel_t               sel,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [IADDR_W-1:0] iaddr
);
    logic [BYTE_W-1:0] alo_q;
    logic [AHI_W-1:0]  ahi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alo_q <= '0;
            ahi_q <= '0;
        end else begin
            if (sel.alo) alo_q <= host_wdata;
            if (sel.ahi) ahi_q <= host_wdata[AHI_W-1:0];
        end
    end

    assign iaddr = {ahi_q, alo_q};

    // R6: address holds unless one of its two registers is written
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(sel.alo || sel.ahi) |=> $stable(iaddr));
endmodule

// File: rtl/ibw_data_hold.sv
module ibw_data_hold
    import ibw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  sel_t                     sel,
    input  logic [BYTE_W-1:0]        host_wdata,
    output logic [WORD_W-BYTE_W-1:0] hold_hi
);
    logic [TOP_W-1:0]  top_q;
    logic [BYTE_W-1:0] mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            mid_q <= '0;
        end else begin
            if (sel.top) top_q <= host_wdata[TOP_W-1:0];
            if (sel.mid) mid_q <= host_wdata;
        end
    end

    assign hold_hi = {top_q, mid_q};

    // R6: holding bytes persist across a commit
    p_hold_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (sel.low && !sel.mid && !sel.top) |=> $stable(hold_hi));
endmodule

// File: rtl/ibw_commit.sv
module ibw_commit
    import ibw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  sel_t                     sel,
    input  logic [BYTE_W-1:0]        host_wdata,
    input  logic [WORD_W-BYTE_W-1:0] hold_hi,
    input  logic [IADDR_W-1:0]       iaddr,
    output logic                     wr_en,
    output commit_t                  out_q
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            out_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            wr_en   <= sel.low;
            if (sel.low) begin
                out_q.addr <= iaddr;
                out_q.word <= join_word(hold_hi[WORD_W-BYTE_W-1:BYTE_W],
                                        hold_hi[BYTE_W-1:0], host_wdata);
            end
        end
    end

    // R2: a low-byte write yields the strobe on the next cycle, nothing else does
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (rst)
        sel.low |=> wr_en);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !sel.low |=> !wr_en);
    // R3: low byte of the word is the byte sampled with the commit
    p_low_byte_r3: assert property (@(posedge clk) disable iff (rst)
        sel.low |=> (out_q.word[BYTE_W-1:0] == $past(host_wdata)));
    // R5: committed address is the address register content
    p_addr_carry_r5: assert property (@(posedge clk) disable iff (rst)
        sel.low |=> (out_q.addr == $past(iaddr)));
    // R10: outputs only move with a strobe
    p_out_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !wr_en) |-> $stable(out_q));
    // R8: first cycle after reset never strobes
    p_reset_quiet_r8: assert property (@(posedge clk)
        !past_ok |-> !wr_en);
endmodule

// File: rtl/ibw_port.sv
module ibw_port
    import ibw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic                reg_wr_en,
    output logic [IADDR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0]   reg_wdata
);
    sel_t                     sel;
    logic [IADDR_W-1:0]       iaddr;
    logic [WORD_W-BYTE_W-1:0] hold_hi;
    commit_t                  out_q;

    ibw_decode u_dec (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr), .sel(sel)
    );

    ibw_addr_regs u_addr (
        .clk(clk), .rst(rst), .sel(sel), .host_wdata(host_wdata), .iaddr(iaddr)
    );

    ibw_data_hold u_hold (
        .clk(clk), .rst(rst), .sel(sel), .host_wdata(host_wdata), .hold_hi(hold_hi)
    );

    ibw_commit u_com (
        .clk(clk), .rst(rst), .sel(sel), .host_wdata(host_wdata),
        .hold_hi(hold_hi), .iaddr(iaddr), .wr_en(reg_wr_en), .out_q(out_q)
    );

    assign reg_addr  = out_q.addr;
    assign reg_wdata = out_q.word;
endmodule

// File: tb/ibw_port_test.sv
module ibw_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        reg_wr_en;
    logic [9:0]  reg_addr;
    logic [19:0] reg_wdata;

    ibw_port uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the register state
    logic [3:0]  m_top;
    logic [7:0]  m_mid, m_alo;
    logic [1:0]  m_ahi;
    logic [9:0]  e_addr;
    logic [19:0] e_word;

    function automatic logic [19:0] exp_word(input logic [3:0] t, input logic [7:0] m,
                                             input logic [7:0] l);
        return {t, m, l};
    endfunction

    function automatic logic [9:0] exp_addr(input logic [1:0] h, input logic [7:0] l);
        return {h, l};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_top = '0; m_mid = '0; m_alo = '0; m_ahi = '0; e_addr = '0; e_word = '0;
    endtask

    // drive one cycle (write or idle) at negedge, check outputs at the next negedge
    task automatic cycle(input logic we, input logic [2:0] a, input logic [7:0] d,
                         input string req);
        logic commit;
        host_we = we; host_addr = a; host_wdata = d;
        commit = we && (a == 3'd0);
        if (commit) begin
            e_word = exp_word(m_top, m_mid, d);
            e_addr = exp_addr(m_ahi, m_alo);
        end
        if (we) begin
            case (a)
                3'd1: m_mid = d;
                3'd2: m_top = d[3:0];
                3'd6: m_alo = d;
                3'd7: m_ahi = d[1:0];
                default: ;
            endcase
        end
        @(negedge clk);
        check({req, " strobe"}, {31'd0, reg_wr_en}, {31'd0, commit});
        check({req, " addr"}, {22'd0, reg_addr}, {22'd0, e_addr});
        check({req, " word"}, {12'd0, reg_wdata}, {12'd0, e_word});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 reset strobe", {31'd0, reg_wr_en}, 32'd0);
        check("R1 reset addr", {22'd0, reg_addr}, 32'd0);
        check("R1 reset word", {12'd0, reg_wdata}, 32'd0);
        // R1 R2 R3: commit with nothing loaded has zero upper bits
        cycle(1, 3'd0, 8'h3C, "R1/R2");
        cycle(0, 3'd0, 8'hFF, "R2 one-cycle");
        // R5: full address, upper bits of A7 ignored
        cycle(1, 3'd6, 8'hA5, "R7 alo");
        cycle(1, 3'd7, 8'hFE, "R7 ahi");
        // R4: DR2 upper bits ignored
        cycle(1, 3'd2, 8'hF9, "R7 top");
        cycle(1, 3'd1, 8'h81, "R7 mid");
        cycle(1, 3'd0, 8'h42, "R3/R4/R5");
        check("R5 addr value", {22'd0, reg_addr}, 32'h2A5);
        check("R4 word value", {12'd0, reg_wdata}, 32'h98142);
        // R6: only new low byte, back to back
        cycle(1, 3'd0, 8'h11, "R6 reuse");
        cycle(1, 3'd0, 8'h22, "R6 back-to-back");
        check("R6 word value", {12'd0, reg_wdata}, 32'h98122);
        // R7: unused addresses change nothing
        cycle(1, 3'd3, 8'hFF, "R7 a3");
        cycle(1, 3'd4, 8'hFF, "R7 a4");
        cycle(1, 3'd5, 8'hFF, "R7 a5");
        cycle(1, 3'd0, 8'h00, "R7 after unused");
        check("R7 state kept", {12'd0, reg_wdata}, 32'h98100);
        // R9: bus activity with we low
        for (int i = 0; i < 8; i++) cycle(0, i[2:0], 8'hEE, "R9 idle");
        cycle(1, 3'd0, 8'h01, "R9 after idle");
        check("R9 state kept", {22'd0, reg_addr}, 32'h2A5);
        // random traffic, R10 covered by addr/word checks on idle cycles
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            a = $urandom_range(0, 7);
            cycle(($urandom_range(0, 3) != 0), a, $urandom_range(0, 255), "R10 random");
        end
        // R8: reset coincident with a commit
        host_we = 1; host_addr = 3'd0; host_wdata = 8'h77; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R8 no strobe", {31'd0, reg_wr_en}, 32'd0);
        check("R8 word cleared", {12'd0, reg_wdata}, 32'd0);
        cycle(1, 3'd0, 8'h5A, "R1 holding cleared");
        check("R1 cleared word", {12'd0, reg_wdata}, 32'h0005A);
        cycle(0, 3'd0, 8'h00, "R10 final");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule